// File: doc/BRIEF.md
# Multi-Mode Operand Resolver

This block turns one operand specifier into an operand value. A specifier has three parts: a mode code, a field that holds an address or a constant, and a register number. On a start pulse the block captures the specifier, the current program counter and an operand size. It then reads the register file through a combinational read port and issues zero, one or two reads to a single-port data memory. For the pointer-stepping modes it writes the updated pointer back to the register file. It ends with a one-cycle done pulse. The operand, the effective address and a flag that says whether an effective address exists stay on the outputs until the next resolution updates them.

The register file and the data memory sit outside the block. The memory returns read data in the cycle after the block raises its read strobe. The instruction decoder and the ALU are not part of this block. A decoder pulses start with the fields, waits for done, and then takes the operand.

Top module: `ea_resolver`

## Requirements
- R1: After reset, busy, done, mem_rd and rf_we are all low.
- R2: Mode code 0 (literal) returns the field as the operand, makes no memory read, and leaves ea_valid low.
- R3: Mode code 1 (absolute) uses the field as the effective address and makes one memory read. The read data becomes the operand.
- R4: Mode code 2 (double reference) reads the location named by the field to get a pointer, then reads at that pointer. The pointer is the effective address, and the block makes exactly two reads.
- R5: Mode code 3 (register value) returns the selected register with no memory read and ea_valid low.
- R6: Mode code 4 (register pointer) uses the selected register as the effective address and makes one read.
- R7: Mode code 5 (based) uses field plus selected register as the effective address and makes one read.
- R8: Mode code 6 (PC offset) uses field plus the pc input captured at start as the effective address and makes one read.
- R9: Mode code 7 (post-step) uses the register's old value as the effective address and writes back that value plus the size input (1, 2 or 4 bytes), once.
- R10: Mode code 8 (pre-step) subtracts the size from the register, uses the result as the effective address and writes the result back, once.
- R11: All address sums and register steps wrap modulo 2^AW.
- R12: busy rises on the edge after an accepted start and stays high through the single-cycle done pulse. A start while busy is ignored.
- R13: Mode codes 9 to 15 behave as code 0.
- R14: done is high after (reads + 2) clock edges, counting the edge that samples start. mem_rd is only high inside a resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a resolution (taken only when idle) |
| mode | input | 4 | Addressing mode code |
| field | input | AW | Address or constant field |
| reg_sel | input | RW | Register number |
| pc | input | AW | Current program counter |
| step_bytes | input | 3 | Operand size in bytes: 1, 2 or 4 |
| rf_sel | output | RW | Register file read/write index |
| rf_rdata | input | AW | Register file read data (combinational) |
| rf_we | output | 1 | Register write-back strobe |
| rf_wdata | output | AW | Register write-back value |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | AW | Memory read data, valid the cycle after mem_rd |
| busy | output | 1 | Resolution in progress |
| done | output | 1 | One-cycle completion pulse |
| operand | output | AW | Resolved operand |
| eff_addr | output | AW | Effective address |
| ea_valid | output | 1 | The last mode had an effective address |

## Verification
The bench targets the cases where a plausible bug gives a wrong but believable operand. In the double-reference mode, a design that forgets the second read returns the pointer as the operand and finishes a cycle early. The pre-step and post-step modes are easy to swap: a swap shows up as an effective address off by the size and a write-back that does not match. Address sums that run past the top of the space check that no carry leaks or saturates. A second start sent in the middle of a resolution would, if accepted, replace the captured fields and change the result or produce an extra done. Unassigned mode codes must not start a memory read.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_LIT   = 4'd0,
    AM_ABS   = 4'd1,
    AM_DREF  = 4'd2,
    AM_RVAL  = 4'd3,
    AM_RPTR  = 4'd4,
    AM_BASED = 4'd5,
    AM_PCOFS = 4'd6,
    AM_POST  = 4'd7,
    AM_PRE   = 4'd8
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } rstate_e;
endpackage

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     field,
  input  logic [AW-1:0]     regv,
  input  logic [AW-1:0]     pcv,
  input  logic [2:0]        step,
  output logic [AW-1:0]     ea,
  output logic [1:0]        nreads,
  output logic              wb_en,
  output logic [AW-1:0]     wb_val,
  output logic [AW-1:0]     direct_val
);
  logic [AW-1:0] base, offs, step_ext;
  logic          sub;

  assign step_ext = {{(AW-3){1'b0}}, step};

  always_comb begin
    base       = field;
    offs       = '0;
    sub        = 1'b0;
    nreads     = 2'd0;
    wb_en      = 1'b0;
    direct_val = field;
    case (amode_e'(mode))
      AM_ABS:   nreads = 2'd1;
      AM_DREF:  nreads = 2'd2;
      AM_RVAL:  direct_val = regv;
      AM_RPTR:  begin base = regv; nreads = 2'd1; end
      AM_BASED: begin offs = regv; nreads = 2'd1; end
      AM_PCOFS: begin offs = pcv;  nreads = 2'd1; end
      AM_POST:  begin base = regv; nreads = 2'd1; wb_en = 1'b1; end
      AM_PRE:   begin base = regv; offs = step_ext; sub = 1'b1;
                      nreads = 2'd1; wb_en = 1'b1; end
      default:  direct_val = field;
    endcase
  end

  // single shared adder for all address forms
  assign ea     = sub ? (base - offs) : (base + offs);
  assign wb_val = sub ? ea : (regv + step_ext);
endmodule

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [1:0]    nreads,
  input  logic [AW-1:0] ea,
  input  logic          wb_en,
  input  logic [AW-1:0] direct_val,
  input  logic [AW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic          rf_we,
  output logic [AW-1:0] operand,
  output logic [AW-1:0] eff_addr,
  output logic          ea_valid
);
  rstate_e       state_q, state_d;
  logic          sec_q, sec_d;
  logic [AW-1:0] op_q, op_d, ea_q, ea_d;
  logic          eav_q, eav_d;
  logic          op_en, ea_en;

  always_comb begin
    state_d  = state_q;
    sec_d    = sec_q;
    op_d     = op_q;
    ea_d     = ea_q;
    eav_d    = eav_q;
    op_en    = 1'b0;
    ea_en    = 1'b0;
    mem_rd   = 1'b0;
    mem_addr = ea;
    rf_we    = 1'b0;
    case (state_q)
      ST_IDLE: if (launch) state_d = ST_CALC;
      ST_CALC: begin
        rf_we = wb_en;
        ea_en = 1'b1;
        if (nreads == 2'd0) begin
          op_en   = 1'b1;
          op_d    = direct_val;
          eav_d   = 1'b0;
          state_d = ST_DONE;
        end else begin
          mem_rd  = 1'b1;
          ea_d    = ea;
          eav_d   = 1'b1;
          sec_d   = (nreads == 2'd2);
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (sec_q) begin
          mem_rd   = 1'b1;
          mem_addr = mem_rdata;
          ea_en    = 1'b1;
          ea_d     = mem_rdata;
          sec_d    = 1'b0;
        end else begin
          op_en   = 1'b1;
          op_d    = mem_rdata;
          state_d = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sec_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sec_q   <= sec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0;
    end else if (op_en) begin
      op_q <= op_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q  <= '0;
      eav_q <= 1'b0;
    end else if (ea_en) begin
      ea_q  <= ea_d;
      eav_q <= eav_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_DONE);
  assign operand  = op_q;
  assign eff_addr = ea_q;
  assign ea_valid = eav_q;
endmodule

// File: rtl/ea_resolver.sv
module ea_resolver
  import ea_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 8,
  localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     field,
  input  logic [RW-1:0]     reg_sel,
  input  logic [AW-1:0]     pc,
  input  logic [2:0]        step_bytes,
  output logic [RW-1:0]     rf_sel,
  input  logic [AW-1:0]     rf_rdata,
  output logic              rf_we,
  output logic [AW-1:0]     rf_wdata,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  input  logic [AW-1:0]     mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [AW-1:0]     operand,
  output logic [AW-1:0]     eff_addr,
  output logic              ea_valid
);
  logic [MODE_W-1:0] cmd_mode;
  logic [AW-1:0]     cmd_field, cmd_pc;
  logic [RW-1:0]     cmd_reg;
  logic [2:0]        cmd_step;
  logic              launch;
  logic [AW-1:0]     calc_ea, calc_direct;
  logic [1:0]        calc_nreads;
  logic              calc_wb_en;

  assign launch = start & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_mode  <= '0;
      cmd_field <= '0;
      cmd_pc    <= '0;
      cmd_reg   <= '0;
      cmd_step  <= '0;
    end else if (launch) begin
      cmd_mode  <= mode;
      cmd_field <= field;
      cmd_pc    <= pc;
      cmd_reg   <= reg_sel;
      cmd_step  <= step_bytes;
    end
  end

  assign rf_sel = cmd_reg;

  ea_calc #(.AW(AW)) u_calc (
    .mode       (cmd_mode),
    .field      (cmd_field),
    .regv       (rf_rdata),
    .pcv        (cmd_pc),
    .step       (cmd_step),
    .ea         (calc_ea),
    .nreads     (calc_nreads),
    .wb_en      (calc_wb_en),
    .wb_val     (rf_wdata),
    .direct_val (calc_direct)
  );

  ea_seq #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .nreads     (calc_nreads),
    .ea         (calc_ea),
    .wb_en      (calc_wb_en),
    .direct_val (calc_direct),
    .mem_rdata  (mem_rdata),
    .busy       (busy),
    .done       (done),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .rf_we      (rf_we),
    .operand    (operand),
    .eff_addr   (eff_addr),
    .ea_valid   (ea_valid)
  );
endmodule

// File: rtl/ea_resolver_chk.sv
module ea_resolver_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic mem_rd,
  input logic rf_we
);
  // R12
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  // R12
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R12
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R14
  read_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (busy && !done));

  // R9 R10
  single_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);
endmodule

bind ea_resolver ea_resolver_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .mem_rd (mem_rd),
  .rf_we  (rf_we)
);

// File: tb/sim_ea_resolver.sv
module sim_ea_resolver;
  localparam int CLK_P = 10;
  localparam int AW    = 16;
  localparam int NREG  = 8;
  localparam logic [15:0] PCV = 16'h3000;

  typedef struct packed {
    logic [3:0]  md;
    logic [15:0] fld;
    logic [2:0]  rs;
    logic [2:0]  sz;
    logic        ovr;
    logic [15:0] ovv;
    logic [15:0] op;
    logic [15:0] ea;
    logic        eav;
    logic [1:0]  nrd;
    logic        wr;
    logic [15:0] raft;
    logic        wrp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 16'hBEEF, 3'd0, 3'd1, 1'b0, 16'h0000, 16'hBEEF, 16'h0000, 1'b0, 2'd0, 1'b0, 16'h0020, 1'b0},
    '{4'd1, 16'h1234, 3'd1, 3'd1, 1'b0, 16'h0000, 16'h34CB, 16'h1234, 1'b1, 2'd1, 1'b0, 16'h0120, 1'b0},
    '{4'd2, 16'h0045, 3'd2, 3'd1, 1'b0, 16'h0000, 16'hBA45, 16'h45BA, 1'b1, 2'd2, 1'b0, 16'h0220, 1'b0},
    '{4'd3, 16'h0000, 3'd3, 3'd1, 1'b0, 16'h0000, 16'h0320, 16'h0000, 1'b0, 2'd0, 1'b0, 16'h0320, 1'b0},
    '{4'd4, 16'h0000, 3'd5, 3'd1, 1'b0, 16'h0000, 16'h20DF, 16'h0520, 1'b1, 2'd1, 1'b0, 16'h0520, 1'b0},
    '{4'd5, 16'h0010, 3'd2, 3'd1, 1'b0, 16'h0000, 16'h30CF, 16'h0230, 1'b1, 2'd1, 1'b0, 16'h0220, 1'b0},
    '{4'd6, 16'h0044, 3'd4, 3'd1, 1'b0, 16'h0000, 16'h44BB, 16'h3044, 1'b1, 2'd1, 1'b0, 16'h0420, 1'b0},
    '{4'd7, 16'h0000, 3'd6, 3'd2, 1'b0, 16'h0000, 16'h20DF, 16'h0620, 1'b1, 2'd1, 1'b1, 16'h0622, 1'b0},
    '{4'd8, 16'h0000, 3'd1, 3'd4, 1'b0, 16'h0000, 16'h1CE3, 16'h011C, 1'b1, 2'd1, 1'b1, 16'h011C, 1'b0},
    '{4'd7, 16'h0000, 3'd0, 3'd1, 1'b0, 16'h0000, 16'h20DF, 16'h0020, 1'b1, 2'd1, 1'b1, 16'h0021, 1'b0},
    '{4'd6, 16'hE000, 3'd0, 3'd1, 1'b0, 16'h0000, 16'h00FF, 16'h1000, 1'b1, 2'd1, 1'b0, 16'h0020, 1'b1},
    '{4'd5, 16'hFFF0, 3'd7, 3'd1, 1'b0, 16'h0000, 16'h10EF, 16'h0710, 1'b1, 2'd1, 1'b0, 16'h0720, 1'b1},
    '{4'd8, 16'h0000, 3'd2, 3'd2, 1'b1, 16'h0001, 16'hFF00, 16'hFFFF, 1'b1, 2'd1, 1'b1, 16'hFFFF, 1'b1},
    '{4'd7, 16'h0000, 3'd4, 3'd4, 1'b1, 16'hFFFE, 16'hFE01, 16'hFFFE, 1'b1, 2'd1, 1'b1, 16'h0002, 1'b1},
    '{4'hC, 16'h7777, 3'd3, 3'd1, 1'b0, 16'h0000, 16'h7777, 16'h0000, 1'b0, 2'd0, 1'b0, 16'h0320, 1'b0}
  };

  logic        clk, rst_n, start;
  logic [3:0]  mode;
  logic [15:0] field;
  logic [2:0]  reg_sel, rf_sel, step_bytes;
  logic [15:0] rf_rdata, rf_wdata, mem_addr, mem_rdata, operand, eff_addr;
  logic        rf_we, mem_rd, busy, done, ea_valid;

  logic [15:0] regs [NREG];
  logic        preset, pv_en;
  logic [2:0]  pv_idx;
  logic [15:0] pv_val;

  int checks = 0;
  int errors = 0;

  ea_resolver #(.AW(AW), .NREG(NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .field(field),
    .reg_sel(reg_sel), .pc(PCV), .step_bytes(step_bytes), .rf_sel(rf_sel),
    .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .operand(operand), .eff_addr(eff_addr), .ea_valid(ea_valid)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // register file model: one writer process
  always @(posedge clk) begin
    if (preset) begin
      for (int i = 0; i < NREG; i++) regs[i] <= 16'(16'h0100 * i + 16'h0020);
      if (pv_en) regs[pv_idx] <= pv_val;
    end else if (rf_we) begin
      regs[rf_sel] <= rf_wdata;
    end
  end
  assign rf_rdata = regs[rf_sel];

  // memory model: contents of address a are {a[7:0], ~a[7:0]}, one-cycle latency
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= {mem_addr[7:0], ~mem_addr[7:0]};
  end

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic string mtag(input logic [3:0] md, input logic wrp);
    if (wrp) return "R11";
    case (md)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4: return "R6";
      4'd5: return "R7";
      4'd6: return "R8";
      4'd7: return "R9";
      4'd8: return "R10";
      default: return "R13";
    endcase
  endfunction

  task automatic run_vec(input vec_t v);
    int n = 0, rds = 0, wrs = 0;
    logic busy_ok = 1'b1;
    string tg = mtag(v.md, v.wrp);
    @(negedge clk);
    preset = 1'b1; pv_en = v.ovr; pv_idx = v.rs; pv_val = v.ovv;
    @(negedge clk);
    preset = 1'b0; pv_en = 1'b0;
    mode = v.md; field = v.fld; reg_sel = v.rs; step_bytes = v.sz; start = 1'b1;
    forever begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      n++;
      if (mem_rd) rds++;
      if (rf_we) wrs++;
      if (done) break;
      if (!busy) busy_ok = 1'b0;
      if (n > 20) break;
    end
    chk(done, tg, "done seen", 32'(done), 32'd1);
    chk(operand == v.op, tg, "operand", 32'(operand), 32'(v.op));
    chk(ea_valid == v.eav, tg, "ea_valid", 32'(ea_valid), 32'(v.eav));
    if (v.eav) chk(eff_addr == v.ea, tg, "eff_addr", 32'(eff_addr), 32'(v.ea));
    chk(rds == int'(v.nrd), tg, "memory reads", 32'(rds), 32'(v.nrd));
    chk(wrs == int'(v.wr), tg, "register writes", 32'(wrs), 32'(v.wr));
    chk(regs[v.rs] == v.raft, tg, "register after", 32'(regs[v.rs]), 32'(v.raft));
    // R14 latency, R12 busy held
    chk(n == int'(v.nrd) + 2, "R14", "latency", 32'(n), 32'(v.nrd + 2));
    chk(busy_ok, "R12", "busy held until done", 32'(busy_ok), 32'd1);
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; errors++;
    $display("FAIL R12 watchdog act=running exp=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = '0; field = '0; reg_sel = '0;
    step_bytes = 3'd1; preset = 1'b0; pv_en = 1'b0; pv_idx = '0; pv_val = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy, "R1", "busy", 32'(busy), 32'd0);
    chk(!done, "R1", "done", 32'(done), 32'd0);
    chk(!mem_rd, "R1", "mem_rd", 32'(mem_rd), 32'd0);
    chk(!rf_we, "R1", "rf_we", 32'(rf_we), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R12: start while busy is ignored
    begin
      int n = 0, extra = 0;
      @(negedge clk);
      preset = 1'b1;
      @(negedge clk);
      preset = 1'b0;
      mode = 4'd1; field = 16'h1234; reg_sel = 3'd0; step_bytes = 3'd1; start = 1'b1;
      @(posedge clk); @(negedge clk); n++;
      mode = 4'd0; field = 16'h9999; start = 1'b1;
      @(posedge clk); @(negedge clk); n++;
      start = 1'b0;
      while (!done && n < 20) begin
        @(posedge clk); @(negedge clk); n++;
      end
      chk(n == 3, "R12", "latency with second start", 32'(n), 32'd3);
      chk(operand == 16'h34CB, "R12", "operand kept", 32'(operand), 32'h34CB);
      chk(eff_addr == 16'h1234, "R12", "eff_addr kept", 32'(eff_addr), 32'h1234);
      repeat (4) begin
        @(posedge clk); @(negedge clk);
        if (done || busy) extra++;
      end
      chk(extra == 0, "R12", "no extra resolution", 32'(extra), 32'd0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule